// File: doc/BRIEF.md
# Wait-State Generator for Slow Memory

This block holds the processor's bus cycle open for a fixed number of clock periods whenever the address decoder reports an access to a slow device. The decoder's active-high select feeds a short chain of D flip-flops. While the select is low, every flip-flop is held clear. Once the select goes high, a constant one enters the first stage and moves one stage further on each rising clock edge. The ready output stays low until the stage picked by a parameter has become set.

The number of wait states is a build-time parameter from zero to three. Accesses that do not select the slow device pass with ready high, so they see no wait states. Because the chain clears whenever the select is low, each new access starts the full delay again. This holds even when accesses are separated by a single idle cycle. The processor's sampling of ready lies outside the block.

Top module: `wait_state_gen`

## Requirements
- R1: After the active-low reset is released with the select low, ready is high and the first access receives the full wait count.
- R2: Whenever the select is low, ready is high in that same cycle.
- R3: With WAIT_STATES = N greater than 0, ready is low from the cycle in which the select rises until N rising clock edges have sampled the select high, so an access receives exactly N clock periods of ready low.
- R4: With WAIT_STATES = 0, ready is high in every cycle, including cycles in which the select is high.
- R5: Once the wait count has elapsed, ready stays high for as long as the select stays high.
- R6: If the select drops before the count has elapsed, ready goes high in that same cycle, and a later access receives the full count, not the remainder.
- R7: A single clock cycle with the select low between two accesses is enough to restart the count, so the second access also receives N periods of ready low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all chain flip-flops update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset that clears the chain |
| slow_sel | input | 1 | Active-high select from the address decoder for the slow device |
| ready | output | 1 | High lets the bus cycle complete, low requests a wait state |

## Verification
The checker assumes that slow_sel is synchronous to clk and free of X. It also assumes that slow_sel changes only between edges and is held low while reset is asserted. Under these assumptions, a count of consecutive high samples kept in the checker predicts ready exactly. The bench changes the select one nanosecond after each rising edge and keeps it low throughout reset. It drives one shared select into four copies of the block, one for each wait-state setting, so every setting sees the same long accesses, early drops, one-cycle gaps and pseudo-random bursts.

// File: rtl/ws_pkg.sv
package ws_pkg;
   // Largest wait-state count the chain supports.
   localparam int unsigned WS_MAX = 3;
   // Width of the checker's saturating counter of consecutive select samples.
   localparam int unsigned WS_CNT_W = 3;

   // A chain of zero stages cannot be declared, so keep at least one.
   function automatic int unsigned ws_depth(input int unsigned waits);
      return (waits == 0) ? 1 : waits;
   endfunction
endpackage

// File: rtl/ws_stage.sv
module ws_stage (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic d,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (clr) q <= 1'b0;
      else          q <= d;
   end
endmodule

// File: rtl/ws_chain.sv
module ws_chain #(
   parameter int unsigned DEPTH = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   output logic [DEPTH-1:0] taps
);
   logic clear;
   assign clear = ~arm;

   for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      logic d_in;
      if (i == 0) begin : g_head
         // The first stage always loads a one.
         assign d_in = 1'b1;
      end else begin : g_link
         assign d_in = taps[i-1];
      end
      ws_stage u_stage (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (clear),
         .d     (d_in),
         .q     (taps[i])
      );
   end
endmodule

// File: rtl/ws_ready.sv
module ws_ready #(
   parameter int unsigned WAITS = 1,
   parameter int unsigned DEPTH = 1
) (
   input  logic             sel,
   input  logic [DEPTH-1:0] taps,
   output logic             ready
);
   // The tap is combined with the select, so an idle bus or a dropped
   // select releases ready without waiting for the chain to clear.
   assign ready = ~sel | taps[DEPTH-1];
endmodule

// File: rtl/wait_state_gen.sv
module wait_state_gen #(
   parameter int unsigned WAIT_STATES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic slow_sel,
   output logic ready
);
   import ws_pkg::*;

   localparam int unsigned DEPTH = ws_depth(WAIT_STATES);

   if (WAIT_STATES > WS_MAX) begin : g_bad_param
      $error("wait_state_gen: WAIT_STATES must lie between 0 and %0d", WS_MAX);
   end

   if (WAIT_STATES == 0) begin : g_no_wait
      // No chain is built: the cycle is never stretched.
      assign ready = 1'b1;
   end else begin : g_wait
      logic [DEPTH-1:0] taps;

      ws_chain #(.DEPTH(DEPTH)) u_chain (
         .clk   (clk),
         .rst_n (rst_n),
         .arm   (slow_sel),
         .taps  (taps)
      );

      ws_ready #(.WAITS(WAIT_STATES), .DEPTH(DEPTH)) u_ready (
         .sel   (slow_sel),
         .taps  (taps),
         .ready (ready)
      );
   end
endmodule

// File: rtl/ws_checker.sv
module ws_checker #(
   parameter int unsigned WAIT_STATES = 1
) (
   input logic clk,
   input logic rst_n,
   input logic slow_sel,
   input logic ready
);
   import ws_pkg::*;

   localparam logic [WS_CNT_W-1:0] N_W = WS_CNT_W'(WAIT_STATES);

   // Consecutive clock edges that sampled the select high, saturating at N.
   logic [WS_CNT_W-1:0] held;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         held <= '0;
      else if (!slow_sel) held <= '0;
      else if (held < N_W) held <= held + 1'b1;
   end

   p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !slow_sel |-> ready);

   p_wait_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (slow_sel && held < N_W) |-> !ready);

   p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (slow_sel && held == N_W) |-> ready);

   p_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(slow_sel) && !slow_sel) |-> ready);

   if (WAIT_STATES == 0) begin : g_zero
      p_zero_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
         slow_sel |-> ready);
   end else begin : g_nonzero
      p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(slow_sel) |-> !ready);
   end
endmodule

bind wait_state_gen ws_checker #(.WAIT_STATES(WAIT_STATES)) u_ws_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .slow_sel (slow_sel),
   .ready    (ready)
);

// File: tb/test_wait_state_gen.sv
module test_wait_state_gen;
   localparam int NVAR = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sel = 1'b0;
   logic [NVAR-1:0] rdy;

   always #4 clk = ~clk;   // 125 MHz

   for (genvar k = 0; k < NVAR; k++) begin : g_n
      wait_state_gen #(.WAIT_STATES(k)) i_wait_state_gen (
         .clk      (clk),
         .rst_n    (rst_n),
         .slow_sel (sel),
         .ready    (rdy[k])
      );
   end

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;
   string tag = "R1";

   // Behavioural reference: rising edges seen with the select high in this access.
   int run = 0;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n)     run <= 0;
      else if (!sel)  run <= 0;
      else if (run < 16) run <= run + 1;
   end

   task automatic chk_bit(string req, int n, logic act, logic exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s N=%0d ready=%b expected=%b at %0t", req, n, act, exp, $time);
      end
   endtask

   task automatic chk_int(string req, int n, int act, int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s N=%0d low_cycles=%0d expected=%0d at %0t", req, n, act, exp, $time);
      end
   endtask

   // Per-cycle comparison and a count of low cycles in each access.
   int lowc [NVAR];
   int acclen = 0;
   logic prev_sel = 1'b0;
   always @(negedge clk) begin
      if (rst_n && !done) begin
         for (int k = 0; k < NVAR; k++) begin
            logic exp;
            string req;
            exp = !sel || (run >= k);
            if (!sel)        req = "R2";
            else if (k == 0) req = "R4";
            else if (run < k) req = "R3";
            else             req = "R5";
            chk_bit($sformatf("%s (%s)", req, tag), k, rdy[k], exp);
         end
         if (sel) begin
            acclen++;
            for (int k = 0; k < NVAR; k++) if (!rdy[k]) lowc[k]++;
         end else if (prev_sel) begin
            // R3 count: an access of L cycles sees min(L, N) low cycles.
            for (int k = 0; k < NVAR; k++)
               chk_int($sformatf("R3 count (%s)", tag), k, lowc[k], (acclen < k) ? acclen : k);
            acclen = 0;
            for (int k = 0; k < NVAR; k++) lowc[k] = 0;
         end
         prev_sel = sel;
      end
   end

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         done = 1'b1;
         compared++;
         mismatched++;
         $display("FAIL R3 watchdog expired actual=%0d cycles expected=finish", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   // Called at posedge+1: hold the select at v for cyc cycles.
   task automatic drive(bit v, int n);
      sel = v;
      repeat (n) @(posedge clk);
      #1;
   endtask

   logic [15:0] lfsr = 16'hACE1;

   initial begin
      for (int k = 0; k < NVAR; k++) lowc[k] = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      for (int k = 0; k < NVAR; k++) chk_bit("R1 reset", k, rdy[k], 1'b1);
      @(posedge clk);
      #1;
      // R1: first access straight after reset.
      tag = "R1"; drive(1, 6); drive(0, 3);
      tag = "R3"; drive(1, 8); drive(0, 1);
      // R7: one idle cycle between accesses.
      tag = "R7"; drive(1, 6); drive(0, 1); drive(1, 5); drive(0, 2);
      // R6: drops before the count completes.
      tag = "R6"; drive(1, 2); drive(0, 1); drive(1, 1); drive(0, 1);
      drive(1, 5); drive(0, 2);
      // R5: long access held well past the count.
      tag = "R5"; drive(1, 20); drive(0, 2);
      // R4 and the rest under pseudo-random bursts.
      tag = "R4 mix";
      for (int i = 0; i < 300; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         drive(lfsr[0] | lfsr[3], 1 + int'(lfsr[6:5]));
      end
      drive(0, 3);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule